// File: doc/BRIEF.md
# Ordered Read-Address Command Detector

This block sits beside a byte-wide memory and watches its access events, sampled into the core clock domain. A host unlocks one of two non-volatile commands by issuing a fixed run of six reads, each started by a chip-enable falling edge. The first five reads go to a fixed list of addresses. The address of the sixth read then chooses the command: one value asks for a save of the working array into the non-volatile copy (store), and another asks for a reload of the working array from that copy (recall).

The detector recognises the run and nothing more. When the run completes it raises a single-cycle `store_start` or `recall_start` pulse for the transfer engine. Any access that breaks the run sends the detector back to idle without a word. A breaking access is a write, a read to an address that does not belong at that point, or a second chip-enable edge inside one access. A broken run never produces a command. A read of the first key address is always accepted as a fresh beginning, even when it is the access that broke the run.

Top module: `rdseq_cmd_detect`

## Requirements
- R1: While `rst` is high at a rising clock edge, the detector returns to idle with no progress kept, and both command outputs are low in the following cycle.
- R2: A run advances only on a read, which is a cycle with `ce_fall` high and `wr_en` low. The five leading reads must carry the addresses 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, in exactly that order.
- R3: When the five leading reads are followed by a read of 0x0F0F, `store_start` is high for the cycle after the clock edge that samples that sixth strobe.
- R4: When the five leading reads are followed by a read of 0x0F0E, `recall_start` is high for the cycle after the clock edge that samples that sixth strobe.
- R5: A read whose address does not fit the current position of the run sends the detector back to idle, so that no command follows from the reads already made. This includes a sixth read that is neither 0x0F0F nor 0x0F0E.
- R6: A strobe that arrives while `wr_en` is high counts as a write. It never counts as a step, and it sends the detector back to idle.
- R7: If `wr_en` is high in any cycle while an access is open, the detector returns to idle. An access opens with `ce_fall` and closes with `ce_rise`. If `wr_en` is high while no access is open, the detector ignores it and the run continues.
- R8: A second `ce_fall` before the `ce_rise` that closes the current access sends the detector back to idle, and that second strobe does not count as a step.
- R9: A read of 0x0000 that breaks a run is taken as step one of a new run.
- R10: Each command pulse lasts exactly one cycle, and the detector is idle afterwards. Another command then needs all six reads again.
- R11: Never are `store_start` and `recall_start` high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 13 | Access address, sampled when `ce_fall` is high |
| ce_fall | input | 1 | One-cycle strobe marking a chip-enable falling edge (access start) |
| ce_rise | input | 1 | One-cycle strobe marking a chip-enable rising edge (access end) |
| wr_en | input | 1 | Write enable asserted (high means write) |
| store_start | output | 1 | One-cycle pulse that starts a store |
| recall_start | output | 1 | One-cycle pulse that starts a recall |

## Verification
The hardest conditions to produce from the ports are the aborts that carry no address mismatch. One is a write enable that rises in the middle of an otherwise valid read. Another is a second falling-edge strobe before the access has closed. In both cases every address presented is correct, so only the missing command shows the abort. The bench drives these through dedicated access tasks: one leaves the access open while it raises write enable, and one issues two strobes with no closing edge between them. Each task then finishes the rest of an otherwise perfect run and checks that no pulse appears. In contrast, a write enable pulse between closed accesses must still let the store complete.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    localparam int unsigned ADDR_W     = 13;
    localparam int unsigned PREFIX_LEN = 5;
    localparam int unsigned STEP_W     = $clog2(PREFIX_LEN + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [STEP_W-1:0] step_t;

    localparam addr_t STORE_KEY  = 13'h0F0F;
    localparam addr_t RECALL_KEY = 13'h0F0E;
    localparam step_t LAST_STEP  = step_t'(PREFIX_LEN);

    // Address expected at each leading position of the run
    function automatic addr_t prefix_key(input int unsigned idx);
        case (idx)
            0:       prefix_key = 13'h0000;
            1:       prefix_key = 13'h1555;
            2:       prefix_key = 13'h0AAA;
            3:       prefix_key = 13'h1FFF;
            4:       prefix_key = 13'h10F0;
            default: prefix_key = '0;
        endcase
    endfunction

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_READ   = 2'd1,
        EV_WRITE  = 2'd2,
        EV_DOUBLE = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        addr_t     addr;
    } acc_evt_t;

    typedef struct packed {
        logic hit_next;
        logic hit_first;
        logic hit_store;
        logic hit_recall;
    } match_t;

endpackage

// File: rtl/rdseq_access_track.sv
module rdseq_access_track
    import rdseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  addr_t    bus_addr,
    input  logic     ce_fall,
    input  logic     ce_rise,
    input  logic     wr_en,
    output acc_evt_t evt
);

    logic open_q;

    // An access stays open from its falling strobe until its rising strobe
    always_ff @(posedge clk) begin
        if (rst)          open_q <= 1'b0;
        else if (ce_fall) open_q <= 1'b1;
        else if (ce_rise) open_q <= 1'b0;
    end

    always_comb begin
        evt.addr = bus_addr;
        evt.kind = EV_NONE;
        if (ce_fall) begin
            if (open_q)     evt.kind = EV_DOUBLE;
            else if (wr_en) evt.kind = EV_WRITE;
            else            evt.kind = EV_READ;
        end else if (open_q && wr_en) begin
            evt.kind = EV_WRITE;
        end
    end

    // A strobe always leaves the access marked open
    AST_STROBE_OPENS: assert property (@(posedge clk) disable iff (rst)
        ce_fall |=> open_q);  // R8

endmodule

// File: rtl/rdseq_addr_match.sv
module rdseq_addr_match
    import rdseq_pkg::*;
(
    input  addr_t  addr,
    input  step_t  step,
    output match_t hit
);

    logic [PREFIX_LEN-1:0] key_eq;

    for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_key
        assign key_eq[g] = (addr == prefix_key(g));
    end

    always_comb begin
        hit.hit_next = 1'b0;
        for (int i = 0; i < PREFIX_LEN; i++) begin
            if (step == step_t'(i)) hit.hit_next = key_eq[i];
        end
        hit.hit_first  = key_eq[0];
        hit.hit_store  = (step == LAST_STEP) && (addr == STORE_KEY);
        hit.hit_recall = (step == LAST_STEP) && (addr == RECALL_KEY);
    end

endmodule

// File: rtl/rdseq_step_fsm.sv
module rdseq_step_fsm
    import rdseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  acc_kind_e kind,
    input  match_t    hit,
    output step_t     step,
    output logic      store_q,
    output logic      recall_q
);

    step_t step_q, step_d;
    logic  store_d, recall_d;

    always_comb begin
        step_d   = step_q;
        store_d  = 1'b0;
        recall_d = 1'b0;
        case (kind)
            EV_READ: begin
                if (hit.hit_store) begin
                    store_d = 1'b1;
                    step_d  = '0;
                end else if (hit.hit_recall) begin
                    recall_d = 1'b1;
                    step_d   = '0;
                end else if (hit.hit_next) begin
                    step_d = step_q + step_t'(1);
                end else if (hit.hit_first) begin
                    step_d = step_t'(1);
                end else begin
                    step_d = '0;
                end
            end
            EV_WRITE, EV_DOUBLE: step_d = '0;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q   <= '0;
            store_q  <= 1'b0;
            recall_q <= 1'b0;
        end else begin
            step_q   <= step_d;
            store_q  <= store_d;
            recall_q <= recall_d;
        end
    end

    assign step = step_q;

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (kind == EV_WRITE || kind == EV_DOUBLE) |=> (step_q == '0));  // R6
    AST_HOLD_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (rst)
        (kind == EV_NONE) |=> $stable(step_q));  // R2
    AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        step_q <= LAST_STEP);  // R2
    AST_IDLE_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
        (store_q || recall_q) |-> (step_q == '0));  // R10
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (store_q || recall_q) |=> !(store_q || recall_q));  // R10

endmodule

// File: rtl/rdseq_cmd_detect.sv
module rdseq_cmd_detect
    import rdseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              ce_fall,
    input  logic              ce_rise,
    input  logic              wr_en,
    output logic              store_start,
    output logic              recall_start
);

    acc_evt_t evt;
    match_t   hit;
    step_t    step;

    rdseq_access_track u_track (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .ce_fall  (ce_fall),
        .ce_rise  (ce_rise),
        .wr_en    (wr_en),
        .evt      (evt)
    );

    rdseq_addr_match u_match (
        .addr (evt.addr),
        .step (step),
        .hit  (hit)
    );

    rdseq_step_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .kind     (evt.kind),
        .hit      (hit),
        .step     (step),
        .store_q  (store_start),
        .recall_q (recall_start)
    );

    AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(store_start && recall_start));  // R11
    AST_STORE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(store_start) |-> $past(ce_fall && !wr_en));  // R3
    AST_RECALL_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(recall_start) |-> $past(ce_fall && !wr_en));  // R4

endmodule

// File: tb/rdseq_cmd_detect_test.sv
module rdseq_cmd_detect_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] bus_addr = '0;
    logic        ce_fall = 1'b0;
    logic        ce_rise = 1'b0;
    logic        wr_en = 1'b0;
    logic        store_start, recall_start;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic got_st, got_rc, late_st, late_rc;

    always #(CLK_PERIOD/2) clk = ~clk;

    rdseq_cmd_detect uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .ce_fall(ce_fall),
        .ce_rise(ce_rise), .wr_en(wr_en),
        .store_start(store_start), .recall_start(recall_start)
    );

    function automatic logic [12:0] key(input int i);
        case (i)
            0: key = 13'h0000; 1: key = 13'h1555; 2: key = 13'h0AAA;
            3: key = 13'h1FFF; default: key = 13'h10F0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s {store,recall} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One complete access: strobe, one cycle open, closing strobe
    task automatic access(input logic [12:0] a, input logic wr);
        @(negedge clk); bus_addr = a; wr_en = wr; ce_fall = 1'b1;
        @(negedge clk); ce_fall = 1'b0; got_st = store_start; got_rc = recall_start;
        ce_rise = 1'b1;
        @(negedge clk); ce_rise = 1'b0; wr_en = 1'b0;
        late_st = store_start; late_rc = recall_start;
    endtask

    task automatic prefix(input int n);
        for (int i = 0; i < n; i++) access(key(i), 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 outputs after reset", {store_start, recall_start}, 2'b00);
    endtask

    task automatic t_store();
        prefix(5); access(13'h0F0F, 1'b0);
        check("R3 store pulse", {got_st, got_rc}, 2'b10);
        check("R10 pulse one cycle", {late_st, late_rc}, 2'b00);
        access(13'h0F0F, 1'b0);
        check("R10 idle after command", {got_st, got_rc}, 2'b00);
    endtask

    task automatic t_recall();
        prefix(5); access(13'h0F0E, 1'b0);
        check("R4 recall pulse", {got_st, got_rc}, 2'b01);
        check("R11 R10 recall one cycle", {late_st, late_rc}, 2'b00);
    endtask

    task automatic t_order();
        access(key(1), 1'b0); access(key(0), 1'b0);
        for (int i = 2; i < 5; i++) access(key(i), 1'b0);
        access(13'h0F0F, 1'b0);
        check("R2 out-of-order run", {got_st, got_rc}, 2'b00);
    endtask

    task automatic t_wrong_addr();
        prefix(3); access(13'h1234, 1'b0); access(key(3), 1'b0); access(key(4), 1'b0);
        access(13'h0F0F, 1'b0);
        check("R5 wrong address mid-run", {got_st, got_rc}, 2'b00);
        prefix(5); access(13'h0F0D, 1'b0); access(13'h0F0F, 1'b0);
        check("R5 wrong sixth address", {got_st, got_rc}, 2'b00);
    endtask

    task automatic t_write_strobe();
        prefix(2); access(key(2), 1'b1); access(key(3), 1'b0); access(key(4), 1'b0);
        access(13'h0F0E, 1'b0);
        check("R6 write strobe as step", {got_st, got_rc}, 2'b00);
        prefix(5); access(13'h0F0F, 1'b1);
        check("R6 write on final step", {got_st, got_rc}, 2'b00);
    endtask

    task automatic t_write_open();
        prefix(2);
        @(negedge clk); bus_addr = key(2); ce_fall = 1'b1;
        @(negedge clk); ce_fall = 1'b0; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; ce_rise = 1'b1;
        @(negedge clk); ce_rise = 1'b0;
        access(key(3), 1'b0); access(key(4), 1'b0); access(13'h0F0F, 1'b0);
        check("R7 write inside open access", {got_st, got_rc}, 2'b00);
        prefix(3);
        @(negedge clk); wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        access(key(3), 1'b0); access(key(4), 1'b0); access(13'h0F0F, 1'b0);
        check("R7 write with no access open", {got_st, got_rc}, 2'b10);
    endtask

    task automatic t_double();
        prefix(4);
        @(negedge clk); bus_addr = key(4); ce_fall = 1'b1;
        @(negedge clk); ce_fall = 1'b1;
        @(negedge clk); ce_fall = 1'b0; ce_rise = 1'b1;
        @(negedge clk); ce_rise = 1'b0;
        access(13'h0F0F, 1'b0);
        check("R8 double strobe aborts", {got_st, got_rc}, 2'b00);
    endtask

    task automatic t_restart();
        prefix(3); prefix(5); access(13'h0F0E, 1'b0);
        check("R9 restart after 3 steps", {got_st, got_rc}, 2'b01);
        prefix(5); prefix(5); access(13'h0F0F, 1'b0);
        check("R9 restart at final step", {got_st, got_rc}, 2'b10);
        access(key(0), 1'b0); prefix(5); access(13'h0F0F, 1'b0);
        check("R9 repeated first key", {got_st, got_rc}, 2'b10);
    endtask

    task automatic t_reset_mid();
        prefix(5); do_reset(); access(13'h0F0F, 1'b0);
        check("R1 reset clears progress", {got_st, got_rc}, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_store();
        t_recall();
        t_order();
        t_wrong_addr();
        t_write_strobe();
        t_write_open();
        t_double();
        t_restart();
        t_reset_mid();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule